// File: doc/BRIEF.md
# Two-Module Tag Controller with Conflict-Bit Placement

This block holds only the tags of a level-one data cache that is split into two modules. The main module is set associative with conflict tracking. The auxiliary module is a small fully associative store. Each request carries a byte address. Both modules are searched at the same time, and a match in either one is reported as a hit, together with the module and the way or entry that matched.

On a miss the block is always allocated. A free main way in the target set is used first. If the set is full, the controller looks for a main block that has not been referenced since the last miss to that set, and replaces it. If every block in the set has been reused, the new block goes into the auxiliary module instead. There it takes a free entry, or else displaces the least recently used entry. Any displaced block is reported by its block-aligned address.

The block accepts one request at a time. It holds off new requests until the current lookup or fill has finished.

Top module: `dual_module_tag_ctrl`

## Requirements
- R1: After reset both modules are empty, `req_ready_o` is high, and `resp_valid_o` and `evict_valid_o` are low.
- R2: A request whose block is resident in the main module gives a one-cycle response with `resp_hit_o`=1, `resp_aux_o`=0 and `resp_way_o` equal to the main way index (0..MAIN_WAYS-1). The block address is the request address with its low log2(BLOCK_BYTES) bits dropped, and the set is the low log2(MAIN_SETS) bits of the block address.
- R3: A hit on a main block clears that block's conflict flag, so the next miss to its set does not choose it as a victim.
- R4: A miss sets the conflict flags of all blocks in the target main set, using the flag values from before the miss for the victim choice. A block newly placed in the main module starts with its flag clear.
- R5: On a miss, the lowest-numbered invalid way of the target main set is filled first. No eviction is reported, and the response carries `resp_hit_o`=0, `resp_aux_o`=0 and that way.
- R6: If the set is full, the lowest-numbered way whose conflict flag is set is replaced. `evict_valid_o`=1 and `evict_addr_o` gives the old block's address with zero offset bits.
- R7: If the set is full and no flag is set, the block goes into the auxiliary module (`resp_aux_o`=1, `resp_way_o`=entry index). It takes the lowest free entry with no eviction, or, when all entries are valid, the least recently used entry, which is reported on `evict_addr_o`.
- R8: A hit in the auxiliary module responds with `resp_hit_o`=1, `resp_aux_o`=1 and the entry index. Hits and fills both make the entry most recently used.
- R9: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. A hit responds two cycles after acceptance and a miss three cycles after. `req_ready_o` is low from acceptance until the response, and a request held during that time is not taken.
- R10: A block is never resident in both modules, and a block that has just been allocated hits on its next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_ready_o | output | 1 | Controller can take a request |
| resp_valid_o | output | 1 | Response valid for one cycle |
| resp_hit_o | output | 1 | 1 = hit, 0 = miss (allocated) |
| resp_aux_o | output | 1 | 1 = auxiliary module, 0 = main module |
| resp_way_o | output | RW | Main way or auxiliary entry that matched or was filled |
| evict_valid_o | output | 1 | A resident block was displaced (with the response) |
| evict_addr_o | output | ADDR_W | Block-aligned address of the displaced block |

## Verification
A directed phase fills one set and re-references chosen ways before each miss. This shows whether reuse clearing (R3) and miss-time setting of the conflict flags (R4) steer victims to the main or the auxiliary module. A second directed phase reuses the whole set before every miss, so that all auxiliary entries fill and then roll over. An auxiliary hit in the middle of this phase shows whether hits reorder the LRU order. A long random phase over a few sets and a small pool of tags mixes all outcomes, and randomly holds a new request during busy cycles to check that stalls do not lose or duplicate requests.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } ctrl_st_e;
endpackage

// File: rtl/dmc_lowest_set.sv
module dmc_lowest_set #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dmc_main_store.sv
module dmc_main_store #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int SETS   = 128,
  parameter int WAYS   = 3,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic             free_o,
  output logic [WAY_W-1:0] free_way_o,
  output logic             conf_o,
  output logic [WAY_W-1:0] conf_way_o,
  output logic [TAG_W-1:0] conf_tag_o,
  input  logic             touch_i,
  input  logic             miss_i,
  input  logic             fill_i,
  input  logic [WAY_W-1:0] fill_way_i
);
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  conf_q  [SETS];
  logic [WAYS-1:0]  hit_vec, free_vec, conf_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
  end
  assign free_vec = ~valid_q[set_i];
  assign conf_vec = conf_q[set_i] & valid_q[set_i];

  dmc_lowest_set #(.N(WAYS), .IW(WAY_W)) u_hit  (.vec_i(hit_vec),  .found_o(hit_o),  .idx_o(hit_way_o));
  dmc_lowest_set #(.N(WAYS), .IW(WAY_W)) u_free (.vec_i(free_vec), .found_o(free_o), .idx_o(free_way_o));
  dmc_lowest_set #(.N(WAYS), .IW(WAY_W)) u_conf (.vec_i(conf_vec), .found_o(conf_o), .idx_o(conf_way_o));

  always_comb begin
    conf_tag_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (conf_way_o == WAY_W'(w)) conf_tag_o = tag_q[set_i][w];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        conf_q[s]  <= '0;
      end
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (fill_i && fill_way_i == WAY_W'(w)) begin
          valid_q[set_i][w] <= 1'b1;
          conf_q[set_i][w]  <= 1'b0;
        end else if (miss_i) begin
          conf_q[set_i][w]  <= 1'b1;
        end else if (touch_i && hit_way_o == WAY_W'(w)) begin
          conf_q[set_i][w]  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int w = 0; w < WAYS; w++) begin
      if (fill_i && fill_way_i == WAY_W'(w)) tag_q[set_i][w] <= tag_i;
    end
  end

  assert_hit_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> !conf_q[$past(set_i)][$past(hit_way_o)]);
  assert_new_block_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> !conf_q[$past(set_i)][$past(fill_way_i)] && valid_q[$past(set_i)][$past(fill_way_i)]);
  assert_miss_sets_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && !fill_i) |=> (conf_q[$past(set_i)] == '1));
endmodule

// File: rtl/dmc_aux_store.sv
module dmc_aux_store #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 5,
  parameter int ENTRIES = 32,
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic             free_o,
  output logic [IDX_W-1:0] free_idx_o,
  output logic [IDX_W-1:0] lru_idx_o,
  output logic [TAG_W-1:0] lru_tag_o,
  input  logic             touch_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i
);
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [IDX_W-1:0]   age_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] hit_vec, lru_vec;
  logic [IDX_W-1:0]   hit_age;
  logic               lru_any_unused;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = valid_q[e] && (tag_q[e] == tag_i);
    assign lru_vec[e] = valid_q[e] && (age_q[e] == AGE_MAX);
  end

  dmc_lowest_set #(.N(ENTRIES), .IW(IDX_W)) u_hit  (.vec_i(hit_vec),  .found_o(hit_o),  .idx_o(hit_idx_o));
  dmc_lowest_set #(.N(ENTRIES), .IW(IDX_W)) u_free (.vec_i(~valid_q), .found_o(free_o), .idx_o(free_idx_o));
  dmc_lowest_set #(.N(ENTRIES), .IW(IDX_W)) u_lru  (.vec_i(lru_vec),  .found_o(lru_any_unused), .idx_o(lru_idx_o));

  always_comb begin
    hit_age   = '0;
    lru_tag_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hit_idx_o == IDX_W'(e)) hit_age   = age_q[e];
      if (lru_idx_o == IDX_W'(e)) lru_tag_o = tag_q[e];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int e = 0; e < ENTRIES; e++) age_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (fill_i) begin
          if (fill_idx_i == IDX_W'(e)) begin
            valid_q[e] <= 1'b1;
            age_q[e]   <= '0;
          end else if (valid_q[e]) begin
            age_q[e]   <= age_q[e] + 1'b1;
          end
        end else if (touch_i) begin
          if (hit_idx_o == IDX_W'(e))                  age_q[e] <= '0;
          else if (valid_q[e] && age_q[e] < hit_age)   age_q[e] <= age_q[e] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (fill_i && fill_idx_i == IDX_W'(e)) tag_q[e] <= tag_i;
    end
  end

  assert_single_lru_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lru_vec));
  assert_touched_is_mru_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_i && !fill_i) |=> (age_q[$past(hit_idx_o)] == '0));
endmodule

// File: rtl/dual_module_tag_ctrl.sv
module dual_module_tag_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32,
  parameter int MAIN_SETS   = 128,
  parameter int MAIN_WAYS   = 3,
  parameter int AUX_ENTRIES = 32,
  localparam int OFF_W  = $clog2(BLOCK_BYTES),
  localparam int SET_W  = $clog2(MAIN_SETS),
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int MTAG_W = BLK_W - SET_W,
  localparam int MW     = (MAIN_WAYS > 1) ? $clog2(MAIN_WAYS) : 1,
  localparam int AW     = (AUX_ENTRIES > 1) ? $clog2(AUX_ENTRIES) : 1,
  localparam int RW     = (MW > AW) ? MW : AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_aux_o,
  output logic [RW-1:0]     resp_way_o,
  output logic              evict_valid_o,
  output logic [ADDR_W-1:0] evict_addr_o
);
  ctrl_st_e          state_q;
  logic [BLK_W-1:0]  blk_q;
  logic [SET_W-1:0]  set_w;
  logic [MTAG_W-1:0] mtag_w;
  logic              accept, unused_off;

  logic m_hit, m_free, m_conf;
  logic [MW-1:0] m_hit_way, m_free_way, m_conf_way, m_fill_way;
  logic [MTAG_W-1:0] m_conf_tag;
  logic m_touch, m_miss, m_fill;

  logic a_hit, a_free;
  logic [AW-1:0] a_hit_idx, a_free_idx, a_lru_idx, a_fill_idx;
  logic [BLK_W-1:0] a_lru_tag;
  logic a_touch, a_fill;
  logic use_main;

  assign unused_off  = ^req_addr_i[OFF_W-1:0];
  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign set_w       = blk_q[SET_W-1:0];
  assign mtag_w      = blk_q[BLK_W-1:SET_W];

  // placement choice, flags read before this miss updates them
  assign use_main   = m_free || m_conf;
  assign m_fill_way = m_free ? m_free_way : m_conf_way;
  assign a_fill_idx = a_free ? a_free_idx : a_lru_idx;

  assign m_touch = (state_q == ST_LOOK) && m_hit;
  assign a_touch = (state_q == ST_LOOK) && a_hit && !m_hit;
  assign m_miss  = (state_q == ST_FILL);
  assign m_fill  = (state_q == ST_FILL) && use_main;
  assign a_fill  = (state_q == ST_FILL) && !use_main;

  dmc_main_store #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(MAIN_SETS), .WAYS(MAIN_WAYS)
  ) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_w), .tag_i(mtag_w),
    .hit_o(m_hit), .hit_way_o(m_hit_way), .free_o(m_free), .free_way_o(m_free_way),
    .conf_o(m_conf), .conf_way_o(m_conf_way), .conf_tag_o(m_conf_tag),
    .touch_i(m_touch), .miss_i(m_miss), .fill_i(m_fill), .fill_way_i(m_fill_way)
  );

  dmc_aux_store #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENTRIES(AUX_ENTRIES)
  ) u_aux (
    .clk_i(clk_i), .rst_ni(rst_ni), .tag_i(blk_q),
    .hit_o(a_hit), .hit_idx_o(a_hit_idx), .free_o(a_free), .free_idx_o(a_free_idx),
    .lru_idx_o(a_lru_idx), .lru_tag_o(a_lru_tag),
    .touch_i(a_touch), .fill_i(a_fill), .fill_idx_i(a_fill_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      blk_q         <= '0;
      resp_valid_o  <= 1'b0;
      resp_hit_o    <= 1'b0;
      resp_aux_o    <= 1'b0;
      resp_way_o    <= '0;
      evict_valid_o <= 1'b0;
      evict_addr_o  <= '0;
    end else begin
      resp_valid_o  <= 1'b0;
      evict_valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          blk_q   <= req_addr_i[ADDR_W-1:OFF_W];
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (m_hit || a_hit) begin
            resp_valid_o <= 1'b1;
            resp_hit_o   <= 1'b1;
            resp_aux_o   <= !m_hit;
            resp_way_o   <= m_hit ? RW'(m_hit_way) : RW'(a_hit_idx);
            state_q      <= ST_IDLE;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          resp_valid_o <= 1'b1;
          resp_hit_o   <= 1'b0;
          resp_aux_o   <= !use_main;
          resp_way_o   <= use_main ? RW'(m_fill_way) : RW'(a_fill_idx);
          if (use_main && !m_free) begin
            evict_valid_o <= 1'b1;
            evict_addr_o  <= {m_conf_tag, set_w, {OFF_W{1'b0}}};
          end else if (!use_main && !a_free) begin
            evict_valid_o <= 1'b1;
            evict_addr_o  <= {a_lru_tag, {OFF_W{1'b0}}};
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  assert_fill_responds_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL) |=> (resp_valid_o && !resp_hit_o));
  assert_not_in_both_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOK) |-> $onehot0({m_hit, a_hit}));
  assert_evict_on_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> (resp_valid_o && !resp_hit_o));
endmodule

// File: tb/dual_module_tag_ctrl_tb_top.sv
module dual_module_tag_ctrl_tb_top;
  localparam int ADDR_W = 32;
  localparam int SETS   = 128;
  localparam int WAYS   = 3;
  localparam int AUXN   = 32;
  localparam int RW     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, resp_valid, resp_hit, resp_aux, evict_valid;
  logic [RW-1:0] resp_way;
  logic [ADDR_W-1:0] evict_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dual_module_tag_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .resp_valid_o(resp_valid), .resp_hit_o(resp_hit),
    .resp_aux_o(resp_aux), .resp_way_o(resp_way), .evict_valid_o(evict_valid),
    .evict_addr_o(evict_addr)
  );

  // reference state
  int  m_blk [SETS][WAYS];
  bit  m_v   [SETS][WAYS];
  bit  m_c   [SETS][WAYS];
  int  a_blk [AUXN];
  bit  a_v   [AUXN];
  int  lru_q [$];   // front = most recent slot

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic lru_touch(input int slot);
    for (int i = 0; i < lru_q.size(); i++) begin
      if (lru_q[i] == slot) begin
        lru_q.delete(i);
        break;
      end
    end
    lru_q.push_front(slot);
  endtask

  task automatic access(input int blk, input bit hold, input string tag);
    int set, lat, eway, cyc;
    bit ehit, eaux, eev, done;
    int eaddr;
    string req;
    set = blk % SETS;
    ehit = 0; eaux = 0; eev = 0; eway = 0; eaddr = 0; req = "";
    for (int w = 0; w < WAYS; w++) begin
      if (!ehit && m_v[set][w] && m_blk[set][w] == blk) begin
        ehit = 1; eway = w; m_c[set][w] = 0; req = "R2";
      end
    end
    for (int e = 0; e < AUXN; e++) begin
      if (!ehit && a_v[e] && a_blk[e] == blk) begin
        ehit = 1; eaux = 1; eway = e; lru_touch(e); req = "R8";
      end
    end
    if (!ehit) begin
      int fw;
      fw = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!m_v[set][w]) fw = w;
      if (fw >= 0) req = "R5";
      else begin
        for (int w = WAYS - 1; w >= 0; w--) if (m_c[set][w]) fw = w;
        if (fw >= 0) begin
          req = "R6"; eev = 1; eaddr = m_blk[set][fw] * 32;
        end
      end
      for (int w = 0; w < WAYS; w++) m_c[set][w] = 1;
      if (fw >= 0) begin
        eway = fw; m_v[set][fw] = 1; m_blk[set][fw] = blk; m_c[set][fw] = 0;
      end else begin
        int fs;
        fs = -1; eaux = 1; req = "R7";
        for (int e = AUXN - 1; e >= 0; e--) if (!a_v[e]) fs = e;
        if (fs < 0) begin
          fs = lru_q[lru_q.size() - 1];
          eev = 1; eaddr = a_blk[fs] * 32;
        end
        eway = fs; a_v[fs] = 1; a_blk[fs] = blk; lru_touch(fs);
      end
    end
    if (tag != "") req = {tag, "/", req};
    lat = ehit ? 2 : 3;

    req_valid = 1'b1;
    req_addr  = (blk * 32) | ($urandom_range(0, 31));
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (hold) req_addr = req_addr ^ 32'h0001_0000;
    else req_valid = 1'b0;
    done = 0;
    for (cyc = 1; cyc <= 4 && !done; cyc++) begin
      if (cyc > 1) @(negedge clk);
      if (resp_valid) begin
        done = 1;
        check(cyc == lat, {req, " R9"}, "latency", cyc, lat);
        check({resp_hit, resp_aux, resp_way} == {ehit, eaux, RW'(eway)}, req, "hit/aux/way",
              {resp_hit, resp_aux, resp_way}, {ehit, eaux, RW'(eway)});
        check(evict_valid == eev && (!eev || evict_addr == eaddr), req, "evict",
              {evict_valid, evict_addr}, {eev, eaddr});
      end else begin
        check(!req_ready, "R9", "ready while busy", req_ready, 0);
      end
    end
    if (!done) check(0, {req, " R9"}, "no response", 0, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(0, "WDOG", "timeout", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin m_v[s][w] = 0; m_c[s][w] = 0; m_blk[s][w] = 0; end
    for (int e = 0; e < AUXN; e++) begin a_v[e] = 0; a_blk[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1 && resp_valid == 0 && evict_valid == 0, "R1", "reset outputs",
          {req_ready, resp_valid, evict_valid}, 3'b100);

    // set 0: fill, reuse, route to aux, then conflict replacement
    access(0 * SETS, 0, "R5");
    access(0 * SETS, 0, "R10");
    access(1 * SETS, 0, "R5");
    access(2 * SETS, 0, "R5");
    access(0 * SETS, 0, "R3");
    access(1 * SETS, 0, "R3");
    access(3 * SETS, 0, "R3");   // no flag set -> aux
    access(3 * SETS, 0, "R10");
    access(4 * SETS, 0, "R4");   // all flags set -> way0
    access(0 * SETS, 1, "R4");   // way1 replaced
    access(2 * SETS, 1, "R4");   // way2 was flagged: still hits

    // set 3: reuse all ways before every miss so misses fill the aux module
    access(1 * SETS + 3, 0, "");
    access(2 * SETS + 3, 0, "");
    access(3 * SETS + 3, 0, "");
    for (int i = 0; i < 36; i++) begin
      access(1 * SETS + 3, 1, "");
      access(2 * SETS + 3, 1, "");
      access(3 * SETS + 3, 1, "");
      access((10 + i) * SETS + 3, 0, "R7");
      if (i == 20) access(10 * SETS + 3, 0, "R8");
    end

    for (int i = 0; i < 1500; i++) begin
      int sel, blk;
      sel = $urandom_range(0, 2);
      blk = $urandom_range(0, 14) * SETS + (sel == 0 ? 0 : (sel == 1 ? 3 : 9));
      access(blk, $urandom_range(0, 1), "");
    end
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(!resp_valid, "R9", "spurious response", resp_valid, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule